// File: doc/BRIEF.md
# Disk Controller Soft-Switch Register Interface

This block is the register front end of a floppy disk controller. The host reaches it through a window of sixteen addresses. Each access to the window sets or clears one of eight one-bit switches, and it does so whether the access is a read or a write. Three of those switches (the two mode-select latches and the enable latch) decide what a read returns: all ones, the byte from the serial read path, a status byte, or a fixed handshake byte. A ninth state bit comes from an active-low select pin.

The block holds a mode byte that the host can write. It picks one of two drives and drives a motor-enable line to the active drive. When the enable latch is cleared, the motor can stop at once or one second later, depending on a mode bit. The status byte carries a sense bit taken from the active drive's condition inputs and chosen by the switch pattern. The serial read path and the write serializer live outside this block.

Reads are registered. The byte for a read access appears on `acc_rdata` in the cycle after the access. It reflects the switch, motor and mode state that follow that access, and it holds until the next read.

Top module: `floppy_switch_regs`

## Requirements
- R1: On every access (read or write), address bits 3:1 pick switch index 0..7 in the order phase0, phase1, phase2, strobe, enable, drive-select, mode-lo, mode-hi. Address bit 0 = 1 sets that switch and bit 0 = 0 clears it. The switch vector is visible on `switches[7:0]` at those bit positions in the cycle after the access.
- R2: The select state bit is sampled each clock as the inverse of `sel_n`, so it is 1 while `sel_n` is low.
- R3: A read at an odd address returns 8'hFF.
- R4: At an even address, the read returns a value chosen by {mode-hi, mode-lo, enable}. 000 returns FF. 001 returns `rd_data_byte`. mode-lo=1 with mode-hi=0 returns the status byte. mode-hi=1 with mode-lo=0 returns 8'h1F. 11x returns FF.
- R5: The status byte is {sense, 1'b0, motor, mode[4:0]}, where motor is the motor state after the access.
- R6: Sense is selected by {phase2, phase1, phase0, select}. 0001 gives NOT disk_in. 0100 gives NOT motor. 0101 gives NOT track0. 1111 gives NOT installed. All these inputs are taken from the active drive. Every other code gives 0.
- R7: A write whose post-access state has mode-hi=1, mode-lo=1 and enable=0 loads `acc_wdata` into the mode byte. A write with all three set leaves the mode byte unchanged, and so does any read.
- R8: An access that sets enable turns the motor on in the next cycle and cancels a pending turn-off.
- R9: An access that clears enable while mode bit 2 is 1 turns the motor off in the next cycle.
- R10: An access that clears enable while mode bit 2 is 0 keeps the motor on for ONE_SEC_CLKS-1 further cycles. The motor turns off at the ONE_SEC_CLKS-th clock edge after the access edge. A further clear restarts the count.
- R11: `motor_en[d]` is the motor state when the drive-select switch equals d, and 0 otherwise. Changing drives moves the motor line to the new drive.
- R12: A synchronous active-high reset clears the switches, the mode byte, the motor state and the countdown, and sets `acc_rdata` to FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low external select line |
| acc_valid | input | 1 | Access to the window this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 4 | Window address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read result |
| rd_data_byte | input | 8 | Byte from the serial read path |
| disk_in | input | 2 | Per-drive disk present |
| track0 | input | 2 | Per-drive head at track zero |
| installed | input | 2 | Per-drive drive connected |
| switches | output | 8 | Current switch vector |
| motor_en | output | 2 | Per-drive motor enable |

## Verification
On every cycle, the assertions check several things. The addressed switch follows address bit 0 after each access. Odd-address reads yield FF. The mode byte only moves on a write. Setting enable starts the motor, and a fast turn-off stops it. A pending countdown steps down by one each idle cycle, and at most one motor line is high. The bench's scenarios are needed to show the rest: the exact length of the one-second delay, the status and sense encodings for each switch pattern, the hand-over of the motor line between drives, and the mode write being ignored while enable is set. A bench model checks these against random access streams.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    localparam int SW_PH0  = 0;
    localparam int SW_PH1  = 1;
    localparam int SW_PH2  = 2;
    localparam int SW_STRB = 3;
    localparam int SW_EN   = 4;
    localparam int SW_DSEL = 5;
    localparam int SW_MLO  = 6;
    localparam int SW_MHI  = 7;
    localparam int NUM_SW  = 8;
    localparam int NUM_DRV = 2;

    typedef struct packed {
        logic [NUM_SW-1:0] sw;
        logic              sel;
        logic [7:0]        mode;
        logic [7:0]        rdata;
    } regs_t;
endpackage

// File: rtl/fsw_motor_timer.sv
module fsw_motor_timer #(
    parameter int ONE_SEC_CLKS = 7000000
) (
    input  logic clk,
    input  logic rst,
    input  logic on_req,
    input  logic off_req,
    input  logic fast_off,
    output logic motor_nxt,
    output logic motor
);
    localparam int CW = $clog2(ONE_SEC_CLKS + 1);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } mt_t;

    mt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (on_req) begin
            r_d.on  = 1'b1;
            r_d.cnt = '0;
        end else if (off_req) begin
            if (fast_off) begin
                r_d.on  = 1'b0;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = CW'(ONE_SEC_CLKS);
            end
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) r_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign motor_nxt = r_d.on;
    assign motor     = r_q.on;

    // R8
    motor_on_chk: assert property (@(posedge clk) disable iff (rst)
        on_req |=> motor);
    // R9
    fast_off_chk: assert property (@(posedge clk) disable iff (rst)
        (off_req && fast_off && !on_req) |=> !motor);
    // R10
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.cnt != '0 && !on_req && !off_req) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
endmodule

// File: rtl/fsw_read_mux.sv
module fsw_read_mux
    import fsw_pkg::*;
(
    input  logic [NUM_SW-1:0]  sw,
    input  logic               sel,
    input  logic               motor,
    input  logic [7:0]         mode,
    input  logic               odd,
    input  logic [7:0]         data_byte,
    input  logic [NUM_DRV-1:0] disk_in,
    input  logic [NUM_DRV-1:0] track0,
    input  logic [NUM_DRV-1:0] installed,
    output logic [7:0]         value
);
    logic       act;
    logic       sense;
    logic [7:0] status;

    always_comb begin
        act = sw[SW_DSEL];
        case ({sw[SW_PH2], sw[SW_PH1], sw[SW_PH0], sel})
            4'b0001: sense = ~disk_in[act];
            4'b0100: sense = ~motor;
            4'b0101: sense = ~track0[act];
            4'b1111: sense = ~installed[act];
            default: sense = 1'b0;
        endcase
        status = {sense, 1'b0, motor, mode[4:0]};
        if (odd) begin
            value = 8'hFF;
        end else begin
            case ({sw[SW_MHI], sw[SW_MLO], sw[SW_EN]})
                3'b000:         value = 8'hFF;
                3'b001:         value = data_byte;
                3'b010, 3'b011: value = status;
                3'b100, 3'b101: value = 8'h1F;
                default:        value = 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/floppy_switch_regs.sv
module floppy_switch_regs
    import fsw_pkg::*;
#(
    parameter int ONE_SEC_CLKS = 7000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [3:0] acc_addr,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    input  logic [7:0] rd_data_byte,
    input  logic [1:0] disk_in,
    input  logic [1:0] track0,
    input  logic [1:0] installed,
    output logic [7:0] switches,
    output logic [1:0] motor_en
);
    regs_t r_q, r_d;

    logic       en_hit, on_req, off_req;
    logic       motor_nxt, motor;
    logic [7:0] rd_value;

    assign en_hit  = acc_valid && (int'(acc_addr[3:1]) == SW_EN);
    assign on_req  = en_hit && acc_addr[0];
    assign off_req = en_hit && !acc_addr[0];

    fsw_motor_timer #(.ONE_SEC_CLKS(ONE_SEC_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .on_req    (on_req),
        .off_req   (off_req),
        .fast_off  (r_q.mode[2]),
        .motor_nxt (motor_nxt),
        .motor     (motor)
    );

    logic [NUM_SW-1:0] sw_next;

    always_comb begin
        sw_next = r_q.sw;
        if (acc_valid) sw_next[acc_addr[3:1]] = acc_addr[0];
    end

    fsw_read_mux u_mux (
        .sw        (sw_next),
        .sel       (r_q.sel),
        .motor     (motor_nxt),
        .mode      (r_q.mode),
        .odd       (acc_addr[0]),
        .data_byte (rd_data_byte),
        .disk_in   (disk_in),
        .track0    (track0),
        .installed (installed),
        .value     (rd_value)
    );

    always_comb begin
        r_d     = r_q;
        r_d.sw  = sw_next;
        r_d.sel = ~sel_n;
        if (acc_valid && !acc_write) r_d.rdata = rd_value;
        if (acc_valid && acc_write && sw_next[SW_MHI] && sw_next[SW_MLO] && !sw_next[SW_EN])
            r_d.mode = acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.rdata <= 8'hFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_rdata = r_q.rdata;
    assign switches  = r_q.sw;

    genvar d;
    generate
        for (d = 0; d < NUM_DRV; d++) begin : g_drv
            assign motor_en[d] = motor && (r_q.sw[SW_DSEL] == d[0]);
        end
    endgenerate

    // R1
    switch_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (switches[$past(acc_addr[3:1])] == $past(acc_addr[0])));
    // R3
    odd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[0]) |=> (acc_rdata == 8'hFF));
    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(r_q.mode));
    // R11
    one_motor_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(motor_en));
endmodule

// File: tb/floppy_switch_regs_test.sv
`timescale 1ns/1ps
module floppy_switch_regs_test;
    localparam int N = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0, rd_data_byte = '0;
    logic [1:0] disk_in = '0, track0 = '0, installed = '0;
    logic [7:0] acc_rdata, switches;
    logic [1:0] motor_en;

    floppy_switch_regs #(.ONE_SEC_CLKS(N)) uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .rd_data_byte(rd_data_byte), .disk_in(disk_in),
        .track0(track0), .installed(installed), .switches(switches), .motor_en(motor_en)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    logic [7:0] m_sw = '0, m_mode = '0, m_rdata = 8'hFF;
    logic m_sel = 1'b0, m_motor = 1'b0;
    int m_cnt = 0;

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [7:0] sw, logic sel, logic mot, logic [7:0] mode, logic odd);
        logic s;
        logic a;
        a = sw[5];
        case ({sw[2], sw[1], sw[0], sel})
            4'b0001: s = ~disk_in[a];
            4'b0100: s = ~mot;
            4'b0101: s = ~track0[a];
            4'b1111: s = ~installed[a];
            default: s = 1'b0;
        endcase
        if (odd) return 8'hFF;
        case ({sw[7], sw[6], sw[4]})
            3'b001: return rd_data_byte;
            3'b010, 3'b011: return {s, 1'b0, mot, mode[4:0]};
            3'b100, 3'b101: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // called at a falling edge; leaves at the next falling edge
    task automatic step(input logic v, input logic w, input logic [3:0] a, input logic [7:0] d);
        logic [7:0] nsw;
        logic [1:0] exp_me;
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        nsw = m_sw;
        if (v) nsw[a[3:1]] = a[0];
        if (v && a[3:1] == 3'd4) begin
            if (a[0]) begin m_motor = 1'b1; m_cnt = 0; end
            else if (m_mode[2]) begin m_motor = 1'b0; m_cnt = 0; end
            else m_cnt = N;
        end else if (m_cnt != 0) begin
            if (m_cnt == 1) m_motor = 1'b0;
            m_cnt--;
        end
        if (v && !w) m_rdata = exp_read(nsw, m_sel, m_motor, m_mode, a[0]);
        if (v && w && nsw[7] && nsw[6] && !nsw[4]) m_mode = d;
        m_sel = ~sel_n;
        m_sw = nsw;
        @(negedge clk);
        acc_valid = 1'b0;
        exp_me = m_motor ? (m_sw[5] ? 2'b10 : 2'b01) : 2'b00;
        chk(acc_rdata == m_rdata, "R4/R5/R6 rdata", acc_rdata, m_rdata);
        chk(switches == m_sw, "R1 switches", switches, m_sw);
        chk(motor_en == exp_me, "R11 motor_en", {6'b0, motor_en}, {6'b0, exp_me});
    endtask

    initial begin
        #(150000 * 5);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk(acc_rdata == 8'hFF, "R12 rdata", acc_rdata, 8'hFF);
        chk(switches == 8'h00, "R12 switches", switches, 8'h00);
        chk(motor_en == 2'b00, "R12 motor", {6'b0, motor_en}, 8'h00);

        // R3 odd read
        step(1, 0, 4'h1, 0);
        chk(acc_rdata == 8'hFF, "R3 odd read", acc_rdata, 8'hFF);
        // R4 handshake: mode-hi set, mode-lo clear
        step(1, 0, 4'hF, 0);
        step(1, 0, 4'h0, 0);
        chk(acc_rdata == 8'h1F, "R4 handshake", acc_rdata, 8'h1F);
        // R7 mode load: mode-lo set, then write at F
        step(1, 0, 4'hD, 0);
        step(1, 1, 4'hF, 8'h04);
        // R7 ignored with enable set
        step(1, 1, 4'h9, 8'h00);
        step(1, 1, 4'h9, 8'h13);
        step(1, 0, 4'h8, 0);
        step(1, 0, 4'hE, 0);
        chk(acc_rdata[4:0] == 5'h04, "R7 mode kept", acc_rdata, 8'h04);
        // R9 fast off (mode bit 2 set): enable on then off
        step(1, 0, 4'h9, 0);
        chk(motor_en == 2'b01, "R8 motor on", {6'b0, motor_en}, 8'h01);
        step(1, 0, 4'hB, 0);
        chk(motor_en == 2'b10, "R11 drive 1", {6'b0, motor_en}, 8'h02);
        step(1, 0, 4'hA, 0);
        step(1, 0, 4'h8, 0);
        chk(motor_en == 2'b00, "R9 fast off", {6'b0, motor_en}, 8'h00);
        // R10 delayed off: clear mode via write at F with mode-lo set
        step(1, 1, 4'hF, 8'h00);
        step(1, 0, 4'h9, 0);
        step(1, 0, 4'h8, 0);
        for (int k = 1; k < N; k++) step(0, 0, 4'h0, 0);
        chk(motor_en == 2'b01, "R10 still on", {6'b0, motor_en}, 8'h01);
        step(0, 0, 4'h0, 0);
        chk(motor_en == 2'b00, "R10 off at N", {6'b0, motor_en}, 8'h00);
        // R2 / R6: select low, phases 000 -> disk-in-place sense
        step(1, 0, 4'hE, 0);
        step(1, 0, 4'hD, 0);
        sel_n = 1'b0; disk_in = 2'b00;
        step(0, 0, 4'h0, 0);
        step(1, 0, 4'h0, 0);
        chk(acc_rdata[7] == 1'b1, "R2 R6 no disk", acc_rdata, 8'h80);
        disk_in = 2'b01;
        step(1, 0, 4'h0, 0);
        chk(acc_rdata[7] == 1'b0, "R6 disk present", acc_rdata, 8'h00);
        sel_n = 1'b1;

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) sel_n = $urandom_range(0, 1);
            disk_in = 2'($urandom); track0 = 2'($urandom);
            installed = 2'($urandom); rd_data_byte = 8'($urandom);
            if ($urandom_range(0, 1) == 0)
                step(0, 0, 4'($urandom), 8'($urandom));
            else
                step(1, 1'($urandom), 4'($urandom), 8'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule